// File: doc/BRIEF.md
# Chip Power-Down Sequencer with SDRAM Self-Refresh

This block lives inside the memory controller and runs the chip-wide sleep and wake cycle. Software starts a sleep by writing any value to one register address. The block first lets any main-memory transfer in progress finish. It then hands SDRAM to self-refresh through a request/done handshake. After that it raises a global power-down level, which the other units use to stop their clocks. Each peripheral has a stay-awake bit that keeps its clock enable on while the chip sleeps.

Sleep ends when an interrupt arrives or when a unit that is still clocked asks for memory. The sequence then runs in reverse. The power-down level drops first. Self-refresh is then exited through a second handshake. A programmable settling count of memory-clock cycles follows. Only after that count does the register write that started the sleep receive its acknowledge. The bus master is held in that write for the whole sleep. A memory request that arrives during sleep waits until the acknowledge cycle and is granted then.

Top module: `pdseq_top`

## Requirements
- R1: A write (`reg_we`=1) with any data to address `PD_ADDR` (default 0x100108) starts the sequence. An access to any other address gets no acknowledge and starts nothing.
- R2: A read of `PD_ADDR` is acknowledged in the following cycle. It returns 0 on `reg_rdata` and changes no state.
- R3: `sr_enter_req` does not rise while `mem_busy` is high. It rises one cycle after the first cycle in the drain state that sees `mem_busy` low, and the drain state lasts at least one cycle after the write is accepted.
- R4: `sr_enter_req` stays high until `sr_enter_done` is sampled high. `global_pd` is high in the next cycle and `sr_enter_req` is low in that cycle.
- R5: While asleep, a high `irq` or `mem_req` drops `global_pd` one cycle later. `sr_exit_req` rises in that same cycle.
- R6: `sr_exit_req` stays high until `sr_exit_done` is sampled high. A wait of `EXIT_CYCLES` cycles (default 20) follows, and the write acknowledge comes in the cycle after that wait.
- R7: `reg_ack` stays low from acceptance of the starting write until the end of the exit wait. It is a one-cycle pulse, and no access is accepted while the sequence runs or while `reg_ack` is high.
- R8: `clk_en[i]` is a register equal to (not `global_pd`) or `sleepless[i]`, taken from the previous cycle. All bits are 1 after reset.
- R9: `mem_gnt` follows `mem_req` only in the idle state. A request made during the sequence stays ungranted until the acknowledge cycle of the write.
- R10: If a wake source is already high when `sr_enter_done` is sampled, `global_pd` is still high for exactly one cycle, and the full self-refresh exit and exit wait still run.
- R11: After reset: `global_pd`=0, `sr_enter_req`=0, `sr_exit_req`=0, `reg_ack`=0 and every `clk_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until acknowledged |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data (ignored) |
| reg_rdata | output | DATA_W | Read data, always zero |
| reg_ack | output | 1 | One-cycle access acknowledge |
| mem_busy | input | 1 | Main-memory transfer in progress |
| mem_req | input | 1 | Memory request from an always-clocked unit |
| mem_gnt | output | 1 | Grant for `mem_req` |
| irq | input | 1 | Pending interrupt from the interrupt controller |
| sr_enter_req | output | 1 | Command SDRAM into self-refresh |
| sr_enter_done | input | 1 | SDRAM has entered self-refresh |
| sr_exit_req | output | 1 | Command SDRAM out of self-refresh |
| sr_exit_done | input | 1 | SDRAM has left self-refresh |
| sleepless | input | NUM_UNITS | Per-peripheral stay-awake bits |
| clk_en | output | NUM_UNITS | Registered per-peripheral clock enables |
| global_pd | output | 1 | Chip-wide power-down level |

## Verification
Every output of the sequence is one register stage behind the input that moves it. `sr_enter_req`, `global_pd`, `sr_exit_req` and `reg_ack` change in the first cycle after the sampled handshake or wake input, and a read is acknowledged in the first cycle after it is accepted. `clk_en` trails `global_pd` by one further cycle. The acknowledge after self-refresh exit lands exactly `EXIT_CYCLES`+1 cycles after `sr_exit_done` is sampled. The bench drives inputs and samples outputs on the falling edge. From the rising edges in between, it counts the cycle in which each change must appear. It checks the old value just before that cycle and the new value in it, across all stay-awake patterns, several drain and handshake delays, both wake sources, and a wake that is already pending.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE      = 3'd0,
        PS_DRAIN     = 3'd1,
        PS_SR_ENTER  = 3'd2,
        PS_SLEEP     = 3'd3,
        PS_SR_EXIT   = 3'd4,
        PS_EXIT_WAIT = 3'd5
    } pd_state_e;

    typedef struct packed {
        logic rd_go;
        logic wr_go;
    } bus_cmd_t;

    localparam int DEFAULT_EXIT_CYCLES = 20;

    function automatic logic wake_source(input logic irq_i, input logic req_i);
        return irq_i | req_i;
    endfunction

endpackage

// File: rtl/pdseq_regif.sv
module pdseq_regif
    import pdseq_pkg::*;
#(
    parameter int          ADDR_W  = 24,
    parameter int          DATA_W  = 32,
    parameter logic [ADDR_W-1:0] PD_ADDR = ADDR_W'('h100108)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              seq_busy,
    input  logic              seq_done,
    output bus_cmd_t          cmd,
    output logic              reg_ack,
    output logic [DATA_W-1:0] reg_rdata
);

    logic ack_q;
    logic accept;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // one access at a time: blocked while the sequence runs or an ack is out
    assign accept    = reg_req && (reg_addr == PD_ADDR) && !seq_busy && !ack_q;
    assign cmd.wr_go = accept && reg_we;
    assign cmd.rd_go = accept && !reg_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= cmd.rd_go || seq_done;
        end
    end

    assign reg_ack   = ack_q;
    assign reg_rdata = '0;

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int EXIT_CYCLES = DEFAULT_EXIT_CYCLES,
    localparam int CNT_W      = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_go,
    input  logic      mem_busy,
    input  logic      sr_enter_done,
    input  logic      sr_exit_done,
    input  logic      irq,
    input  logic      mem_req,
    output pd_state_e state,
    output logic      seq_done
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYCLES - 1);

    pd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                if (wr_go) state_d = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!mem_busy) state_d = PS_SR_ENTER;
            end
            PS_SR_ENTER: begin
                if (sr_enter_done) state_d = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (wake_source(irq, mem_req)) state_d = PS_SR_EXIT;
            end
            PS_SR_EXIT: begin
                if (sr_exit_done) begin
                    state_d = PS_EXIT_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            PS_EXIT_WAIT: begin
                if (cnt_q == '0) state_d = PS_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state    = state_q;
    assign seq_done = (state_q == PS_EXIT_WAIT) && (cnt_q == '0);

endmodule

// File: rtl/pdseq_clkgate.sv
module pdseq_clkgate #(
    parameter int NUM_UNITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 global_pd,
    input  logic [NUM_UNITS-1:0] sleepless,
    output logic [NUM_UNITS-1:0] clk_en
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst) en_q <= 1'b1;
            else     en_q <= !global_pd || sleepless[u];
        end
        assign clk_en[u] = en_q;
    end

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          DATA_W      = 32,
    parameter logic [ADDR_W-1:0] PD_ADDR = ADDR_W'('h100108),
    parameter int          NUM_UNITS   = 8,
    parameter int          EXIT_CYCLES = DEFAULT_EXIT_CYCLES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 reg_ack,
    input  logic                 mem_busy,
    input  logic                 mem_req,
    output logic                 mem_gnt,
    input  logic                 irq,
    output logic                 sr_enter_req,
    input  logic                 sr_enter_done,
    output logic                 sr_exit_req,
    input  logic                 sr_exit_done,
    input  logic [NUM_UNITS-1:0] sleepless,
    output logic [NUM_UNITS-1:0] clk_en,
    output logic                 global_pd
);

    bus_cmd_t  cmd;
    pd_state_e state;
    logic      seq_done;

    pdseq_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PD_ADDR(PD_ADDR)
    ) u_regif (
        .clk      (clk),
        .rst      (rst),
        .reg_req  (reg_req),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .seq_busy (state != PS_IDLE),
        .seq_done (seq_done),
        .cmd      (cmd),
        .reg_ack  (reg_ack),
        .reg_rdata(reg_rdata)
    );

    pdseq_fsm #(
        .EXIT_CYCLES(EXIT_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wr_go        (cmd.wr_go),
        .mem_busy     (mem_busy),
        .sr_enter_done(sr_enter_done),
        .sr_exit_done (sr_exit_done),
        .irq          (irq),
        .mem_req      (mem_req),
        .state        (state),
        .seq_done     (seq_done)
    );

    assign global_pd    = (state == PS_SLEEP);
    assign sr_enter_req = (state == PS_SR_ENTER);
    assign sr_exit_req  = (state == PS_SR_EXIT);
    assign mem_gnt      = mem_req && (state == PS_IDLE);

    pdseq_clkgate #(
        .NUM_UNITS(NUM_UNITS)
    ) u_clkgate (
        .clk      (clk),
        .rst      (rst),
        .global_pd(global_pd),
        .sleepless(sleepless),
        .clk_en   (clk_en)
    );

endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
    parameter int NUM_UNITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mem_busy,
    input logic                 sr_enter_req,
    input logic                 sr_enter_done,
    input logic                 sr_exit_req,
    input logic                 global_pd,
    input logic                 mem_gnt,
    input logic                 reg_ack,
    input logic [NUM_UNITS-1:0] sleepless,
    input logic [NUM_UNITS-1:0] clk_en
);

    // R3: self-refresh entry never starts over a busy transfer
    a_r3_no_enter_while_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_enter_req) |-> !$past(mem_busy));

    // R4: power-down only follows a completed entry handshake
    a_r4_pd_after_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(global_pd) |-> $past(sr_enter_req && sr_enter_done));

    // R5: dropping power-down goes straight into self-refresh exit
    a_r5_exit_after_pd: assert property (@(posedge clk) disable iff (rst)
        $fell(global_pd) |-> sr_exit_req);

    // R7: acknowledge is a single-cycle pulse
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_ack |=> !reg_ack);

    // R6: no acknowledge while self-refresh exit is pending
    a_r6_no_ack_in_exit: assert property (@(posedge clk) disable iff (rst)
        (sr_exit_req || sr_enter_req || global_pd) |-> !reg_ack);

    // R9: nothing granted while asleep or in a handshake
    a_r9_no_gnt_in_seq: assert property (@(posedge clk) disable iff (rst)
        (global_pd || sr_enter_req || sr_exit_req) |-> !mem_gnt);

    // R8: enables follow the previous cycle's power-down level
    a_r8_enable_track: assert property (@(posedge clk) disable iff (rst)
        !$past(global_pd) |-> (&clk_en));

    a_r8_enable_sleep: assert property (@(posedge clk) disable iff (rst)
        ($past(global_pd) && $stable(sleepless)) |-> (clk_en == sleepless));

endmodule

bind pdseq_top pdseq_checker #(.NUM_UNITS(NUM_UNITS)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .mem_busy     (mem_busy),
    .sr_enter_req (sr_enter_req),
    .sr_enter_done(sr_enter_done),
    .sr_exit_req  (sr_exit_req),
    .global_pd    (global_pd),
    .mem_gnt      (mem_gnt),
    .reg_ack      (reg_ack),
    .sleepless    (sleepless),
    .clk_en       (clk_en)
);

// File: tb/tb_pdseq_top.sv
module tb_pdseq_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NU     = 4;
    localparam int EXITC  = 5;
    localparam logic [ADDR_W-1:0] PDA = 24'h100108;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_req = 1'b0, reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_ack;
    logic              mem_busy = 1'b0, mem_req = 1'b0, irq = 1'b0;
    logic              mem_gnt;
    logic              sr_enter_req, sr_exit_req, global_pd;
    logic              sr_enter_done = 1'b0, sr_exit_done = 1'b0;
    logic [NU-1:0]     sleepless = '0;
    logic [NU-1:0]     clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    pdseq_top #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PD_ADDR(PDA),
        .NUM_UNITS(NU), .EXIT_CYCLES(EXITC)
    ) dut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .mem_busy(mem_busy), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .irq(irq), .sr_enter_req(sr_enter_req),
        .sr_enter_done(sr_enter_done), .sr_exit_req(sr_exit_req),
        .sr_exit_done(sr_exit_done), .sleepless(sleepless), .clk_en(clk_en),
        .global_pd(global_pd)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // one full sleep: drain B cycles, entry delay E, sleep S, exit delay X
    task automatic sleep_run(input logic [NU-1:0] sl, input int b, input int e,
                             input int s, input int x, input bit by_mem, input bit early);
        int drain;
        sleepless = sl;
        mem_busy  = (b > 0);
        reg_req   = 1'b1; reg_we = 1'b1; reg_addr = PDA;
        reg_wdata = {28'h0, sl} ^ 32'hA5A5_0000;
        drain = (b > 1) ? b : 1;
        for (int n = 1; n <= drain; n++) begin
            tick();
            chk("R3", "enter_req during drain", sr_enter_req, 0);
            chk("R7", "ack during drain", reg_ack, 0);
            if (n == b) mem_busy = 1'b0;
        end
        tick();
        chk("R3", "enter_req after drain", sr_enter_req, 1);
        for (int n = 0; n < e; n++) begin
            tick();
            chk("R4", "enter_req held", sr_enter_req, 1);
            chk("R4", "pd before done", global_pd, 0);
        end
        sr_enter_done = 1'b1;
        if (early) begin
            if (by_mem) mem_req = 1'b1; else irq = 1'b1;
        end
        tick();
        sr_enter_done = 1'b0;
        chk("R4", "pd after done", global_pd, 1);
        chk("R4", "enter_req after done", sr_enter_req, 0);
        chk("R8", "enables lag pd", clk_en, {NU{1'b1}});
        if (early) begin
            tick();
            irq = 1'b0;
            chk("R10", "pd one cycle", global_pd, 0);
            chk("R10", "exit_req", sr_exit_req, 1);
            chk("R8", "enables asleep", clk_en, sl);
        end else begin
            for (int n = 0; n < s; n++) begin
                tick();
                chk("R5", "pd held asleep", global_pd, 1);
                chk("R8", "enables asleep", clk_en, sl);
                chk("R7", "ack asleep", reg_ack, 0);
            end
            if (by_mem) mem_req = 1'b1; else irq = 1'b1;
            tick();
            irq = 1'b0;
            chk("R5", "pd drops on wake", global_pd, 0);
            chk("R5", "exit_req on wake", sr_exit_req, 1);
            chk("R9", "no grant in exit", mem_gnt, 0);
        end
        for (int n = 0; n < x; n++) begin
            tick();
            chk("R6", "exit_req held", sr_exit_req, 1);
        end
        sr_exit_done = 1'b1;
        tick();
        sr_exit_done = 1'b0;
        chk("R6", "exit_req cleared", sr_exit_req, 0);
        chk("R8", "enables restored", clk_en, {NU{1'b1}});
        chk("R7", "ack in exit wait", reg_ack, 0);
        for (int n = 1; n < EXITC; n++) begin
            tick();
            chk("R6", "ack before count ends", reg_ack, 0);
            chk("R9", "grant held back", mem_gnt, 0);
        end
        tick();
        chk("R6", "write ack after exit wait", reg_ack, 1);
        chk("R9", "held request granted", mem_gnt, by_mem);
        reg_req = 1'b0; mem_req = 1'b0;
        tick();
        chk("R7", "ack single cycle", reg_ack, 0);
        chk("R1", "back to idle", global_pd | sr_enter_req | sr_exit_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) tick();
        chk("R11", "pd reset", global_pd, 0);
        chk("R11", "enter_req reset", sr_enter_req, 0);
        chk("R11", "exit_req reset", sr_exit_req, 0);
        chk("R11", "ack reset", reg_ack, 0);
        chk("R11", "enables reset", clk_en, {NU{1'b1}});
        rst = 1'b0;
        tick();

        // R9: idle grant follows request
        mem_req = 1'b1;
        #1;
        chk("R9", "idle grant", mem_gnt, 1);
        mem_req = 1'b0;
        #1;
        chk("R9", "idle no grant", mem_gnt, 0);

        // R2: read of the register
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = PDA;
        tick();
        chk("R2", "read ack", reg_ack, 1);
        chk("R2", "read data", reg_rdata, 0);
        reg_req = 1'b0;
        for (int n = 0; n < 3; n++) begin
            tick();
            chk("R2", "read no side effect", sr_enter_req | global_pd | reg_ack, 0);
        end

        // R1: write to another address is ignored
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = PDA + 24'h4; reg_wdata = 32'hFFFF_FFFF;
        for (int n = 0; n < 4; n++) begin
            tick();
            chk("R1", "other address ignored", reg_ack | sr_enter_req | global_pd, 0);
        end
        reg_req = 1'b0;
        tick();

        // sweep every stay-awake pattern with varied timing and wake source
        for (int v = 0; v < (1 << NU); v++) begin
            sleep_run(NU'(v), v % 4, v % 3, 1 + (v % 2), (v / 2) % 3,
                      v[0], (v % 5) == 2);
            tick();
        end
        summary();
    end

endmodule